// File: doc/BRIEF.md
# Serial Configuration Byte Receiver

This block takes single configuration bytes from an asynchronous serial line and keeps them in a volatile flag register. The line runs at a fixed baud rate with eight data bits, no parity bit and one stop bit. The line is sampled at sixteen times the bit rate, and each bit is taken near its middle.

Each byte carries its own check bit. The check bit is chosen so that the whole byte has an even number of ones. A byte that fails this check, or whose stop bit is low, is thrown away. In either case the flags keep their previous values.

The receiver also watches for a separate command: the line held high with no traffic for a long time. When the high run lasts longer than a parameterised number of clock cycles, a debug-hold output is raised. That output clears as soon as the line goes low again. After reset every flag is zero, which is the default configuration.

Top module: `cfg_byte_rx`

## Requirements
- R1: Frames are 8N1 with the data sent least significant bit first. The bit time is OVS*DIV clock cycles, where OVS is 16 and DIV is CLK_HZ/(BAUD_HZ*16), with a minimum of 1. The line passes through a two-flop synchronizer, and each bit is sampled near the middle of the bit.
- R2: After reset, all flag outputs are 0 and `hold_dbg_o` is 0.
- R3: In an accepted byte, bit 0 is the check bit and the other bits map as follows:
  - bit 1 drives `ten_bit_o`
  - bit 2 drives `jeida_o`
  - bit 3 drives `dbg_en_o`
  - bit 4 drives `osd_o`
  - bit 5 drives `xhair_o`
  - bit 6 drives `led_off_o`
  - bit 7 drives `fw_upd_o`

  An accepted byte overwrites all seven flags at once.
- R4: A byte with an odd number of ones across all 8 bits is dropped, and the flags keep their values.
- R5: A frame whose stop bit is sampled low is dropped, and the flags keep their values.
- R6: A low pulse that has ended before the middle of the start bit is not taken as a frame and changes no flag.
- R7: When the synchronized line has been high for more than HOLD_CYC consecutive cycles, `hold_dbg_o` goes to 1. Before that point it stays 0.
- R8: Any low level on the line, including every start bit, restarts the idle timer and clears `hold_dbg_o`.
- R9: While the line is held low for a long time, the flags keep their last accepted values.
- R10: The all-zero byte is accepted and restores the default configuration, with every flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| ten_bit_o | output | 1 | 10-bit colour mode flag |
| jeida_o | output | 1 | Alternate bit mapping flag |
| dbg_en_o | output | 1 | Debug mode requested by byte |
| osd_o | output | 1 | On-screen display enable |
| xhair_o | output | 1 | Crosshair overlay enable |
| led_off_o | output | 1 | Rear LED disable |
| fw_upd_o | output | 1 | Firmware update enable |
| hold_dbg_o | output | 1 | Debug mode from long idle-high line |

## Verification
The bench builds the block with CLK_HZ=1_600_000 and BAUD_HZ=100_000, which gives DIV=1 and a bit time of 16 clocks. With HOLD_CYC=2000, the idle-high threshold can be crossed within a few thousand cycles. This brings the long-idle command within reach of a short run: the bench can probe just below the threshold, just above it, and after it is cleared by a start bit. Because the divider is 1, every oversample tick is a clock edge, so false starts, bad stop bits and mid-bit sampling can be placed at exact cycles.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int OVS = 16;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // flag bits 7..1 of an accepted byte, MSB first
  typedef struct packed {
    logic fw_upd;
    logic led_off;
    logic xhair;
    logic osd;
    logic dbg_en;
    logic jeida;
    logic ten_bit;
  } cfg_flags_t;
endpackage

// File: rtl/cbr_tick_gen.sv
module cbr_tick_gen #(
  parameter int DIV = 54
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(DIV - 1)) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick_o = (cnt_q == CW'(DIV - 1));

      a_r1_tick_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/cbr_uart_rx.sv
module cbr_uart_rx
  import cbr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  output logic       vld_o,
  output logic [7:0] data_o
);
  localparam int OW = $clog2(OVS);
  localparam logic [OW-1:0] MID  = OW'(OVS / 2 - 1);
  localparam logic [OW-1:0] LAST = OW'(OVS - 1);

  rx_state_e     st_q;
  logic [OW-1:0] os_q;
  logic [2:0]    idx_q;
  logic [7:0]    sr_q;
  logic          vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_IDLE;
      os_q  <= '0;
      idx_q <= '0;
      sr_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          RX_IDLE: begin
            if (!rxd_i) begin
              st_q <= RX_START;
              os_q <= '0;
            end
          end
          RX_START: begin
            if (os_q == MID) begin
              os_q  <= '0;
              idx_q <= '0;
              // a false start: the line is back high by mid-bit
              st_q  <= rxd_i ? RX_IDLE : RX_DATA;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (os_q == LAST) begin
              os_q <= '0;
              sr_q <= {rxd_i, sr_q[7:1]};
              if (idx_q == 3'd7) begin
                st_q <= RX_STOP;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (os_q == LAST) begin
              os_q  <= '0;
              vld_q <= rxd_i;
              st_q  <= RX_IDLE;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign vld_o  = vld_q;
  assign data_o = sr_q;

  a_r5_vld_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $past(st_q) == RX_STOP && $past(rxd_i));
  a_r6_data_needs_low_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_START && tick_i && os_q == MID && rxd_i) |=> st_q == RX_IDLE);
endmodule

// File: rtl/cbr_idle_watch.sv
module cbr_idle_watch #(
  parameter int HOLD_CYC = 500_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic hold_o
);
  localparam int unsigned LIMIT = HOLD_CYC + 1;
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!rxd_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hold_o = (cnt_q == CW'(LIMIT));

  a_r8_low_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rxd_i |=> !hold_o);
  a_r7_rise_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(rxd_i));
endmodule

// File: rtl/cfg_byte_rx.sv
module cfg_byte_rx
  import cbr_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int BAUD_HZ  = 115_200,
  parameter int HOLD_CYC = 500_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic ten_bit_o,
  output logic jeida_o,
  output logic dbg_en_o,
  output logic osd_o,
  output logic xhair_o,
  output logic led_off_o,
  output logic fw_upd_o,
  output logic hold_dbg_o
);
  localparam int DIV_RAW = CLK_HZ / (BAUD_HZ * OVS);
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;

  logic [1:0] sync_q;
  logic       rxd_s;
  logic       tick;
  logic       vld;
  logic [7:0] data;
  logic       byte_ok;
  cfg_flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
    end
  end
  assign rxd_s = sync_q[1];

  cbr_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  cbr_uart_rx u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .rxd_i (rxd_s),
    .vld_o (vld),
    .data_o(data)
  );

  cbr_idle_watch #(.HOLD_CYC(HOLD_CYC)) u_idle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rxd_i (rxd_s),
    .hold_o(hold_dbg_o)
  );

  // even parity over the full byte
  assign byte_ok = vld && !(^data);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (byte_ok) begin
      flags_q <= cfg_flags_t'(data[7:1]);
    end
  end

  assign ten_bit_o = flags_q.ten_bit;
  assign jeida_o   = flags_q.jeida;
  assign dbg_en_o  = flags_q.dbg_en;
  assign osd_o     = flags_q.osd;
  assign xhair_o   = flags_q.xhair;
  assign led_off_o = flags_q.led_off;
  assign fw_upd_o  = flags_q.fw_upd;

  a_r4_bad_parity_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && ^data) |=> $stable(flags_q));
  a_r9_hold_no_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld |=> $stable(flags_q));
  a_r3_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && !(^data)) |=> flags_q == $past(data[7:1]));
endmodule

// File: tb/sim_cfg_byte_rx.sv
`timescale 1ns/1ps
module sim_cfg_byte_rx;
  localparam int BIT = 16;
  localparam int HOLD = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic ten_bit, jeida, dbg_en, osd, xhair, led_off, fw_upd, hold_dbg;
  int   n_run = 0;
  int   n_fail = 0;

  always #5 clk = ~clk;

  cfg_byte_rx #(
    .CLK_HZ  (1_600_000),
    .BAUD_HZ (100_000),
    .HOLD_CYC(HOLD)
  ) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .rxd_i     (rxd),
    .ten_bit_o (ten_bit),
    .jeida_o   (jeida),
    .dbg_en_o  (dbg_en),
    .osd_o     (osd),
    .xhair_o   (xhair),
    .led_off_o (led_off),
    .fw_upd_o  (fw_upd),
    .hold_dbg_o(hold_dbg)
  );

  function automatic logic [6:0] flags();
    return {fw_upd, led_off, xhair, osd, dbg_en, jeida, ten_bit};
  endfunction

  function automatic logic [7:0] good(input logic [6:0] f);
    return {f, ^f};
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    @(negedge clk);
    rxd = 1'b0;
    cyc(BIT);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      cyc(BIT);
    end
    rxd = stop;
    cyc(BIT);
    rxd = 1'b1;
    cyc(20);
  endtask

  task automatic t_reset();
    chk("R2 flags after reset", {1'b0, flags()}, 8'h00);
    chk("R2 hold after reset", {7'b0, hold_dbg}, 8'h00);
  endtask

  task automatic t_patterns();
    logic [6:0] pats [4] = '{7'b0000001, 7'b1010101, 7'b0101010, 7'b1111111};
    for (int i = 0; i < 4; i++) begin
      send(good(pats[i]), 1'b1);
      chk("R1 R3 flags after good byte", {1'b0, flags()}, {1'b0, pats[i]});
    end
    send(good(7'b0000100), 1'b1);
    chk("R3 bit3 drives dbg_en", {7'b0, dbg_en}, 8'h01);
    send(good(7'b1000000), 1'b1);
    chk("R3 bit7 drives fw_upd", {7'b0, fw_upd}, 8'h01);
  endtask

  task automatic t_bad_parity();
    send(good(7'b0011001), 1'b1);
    send({7'b1100110, ~^7'b1100110}, 1'b1);
    chk("R4 odd parity dropped", {1'b0, flags()}, 8'h19);
  endtask

  task automatic t_bad_stop();
    send(good(7'b0110000), 1'b0);
    chk("R5 low stop dropped", {1'b0, flags()}, 8'h19);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    rxd = 1'b0;
    cyc(4);
    rxd = 1'b1;
    cyc(200);
    chk("R6 short low no frame", {1'b0, flags()}, 8'h19);
  endtask

  task automatic t_low_hold();
    @(negedge clk);
    rxd = 1'b0;
    cyc(3000);
    chk("R9 flags kept while low", {1'b0, flags()}, 8'h19);
    chk("R8 no hold while low", {7'b0, hold_dbg}, 8'h00);
    rxd = 1'b1;
    cyc(40);
    chk("R9 flags kept after low", {1'b0, flags()}, 8'h19);
  endtask

  task automatic t_idle();
    send(good(7'b0000011), 1'b1);
    cyc(HOLD - 500);
    chk("R7 no hold below limit", {7'b0, hold_dbg}, 8'h00);
    cyc(600);
    chk("R7 hold above limit", {7'b0, hold_dbg}, 8'h01);
    @(negedge clk);
    rxd = 1'b0;
    cyc(6);
    chk("R8 start bit clears hold", {7'b0, hold_dbg}, 8'h00);
    rxd = 1'b1;
    cyc(200);
  endtask

  task automatic t_zero();
    send(good(7'b1111110), 1'b1);
    send(8'h00, 1'b1);
    chk("R10 zero byte defaults", {1'b0, flags()}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(5);
    t_reset();
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_patterns();
    t_bad_parity();
    t_bad_stop();
    t_glitch();
    t_low_hold();
    t_idle();
    t_zero();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule